// File: doc/BRIEF.md
# Byte-Wide Configuration Loader with Readback

This block drives the byte-parallel slave configuration port of a programmable logic target. In load mode it pulses the target's program line, watches the target's init indication come and go, opens the port by raising chip-select and write enable, waits a settling pause, then streams bytes in from a valid/ready source. Each byte is placed on the data bus and strobed by one configuration-clock low/high pulse. Between bytes the target's busy line throttles the stream, and the done and init lines are checked before each byte. After the stream the port is closed and 0xFF filler bytes are clocked until the target reports completion. Every wait has a cycle-count limit, and an expired limit produces an abort pulse and a failure status.

In readback mode the port is selected for reading, with the data bus released, and the requested number of bytes is clocked out of the target. The bytes are handed to a valid/ready consumer. Clocking pauses while the consumer stalls. The sequence ends with chip-select dropped and one extra clock pulse.

Top module: `cfg_par_master`

## Requirements
- R1: After reset and while idle: program, chip-select and write enable are low, the configuration clock is high, the data bus is not driven, and the success and failure flags are low. Program and chip-select are never high together.
- R2: A load first raises program until init is seen high. It then releases program and raises chip-select and write enable only once init and busy are not both high. If either wait exceeds INIT_TO cycles, the block pulses abort and flags failure without ever raising chip-select.
- R3: After chip-select and write enable rise, at least PAUSE_CYC cycles pass before the first clock falls.
- R4: Each accepted byte is driven on the data bus while the clock goes low for one cycle and then high. The target receives the bytes in source order. No further clock falls while busy is high. A busy lasting longer than BUSY_TO cycles causes abort and failure.
- R5: Before each byte, a high done ends the stream early and the load still proceeds to completion. A high init instead causes abort and failure, with no more bytes written.
- R6: After the stream, chip-select and write enable drop and 0xFF bytes are clocked. The load succeeds at the ninth observation of done high with init low. With both held steady, exactly 8 filler pulses occur. If CFG_TO cycles pass first, the block aborts and flags failure.
- R7: Readback raises chip-select with write enable low and the bus undriven. Each byte is one clock pulse followed by capture of the bus. Bytes reach the consumer in target order.
- R8: While a captured byte is offered and not accepted, the byte holds and no clock pulse is issued.
- R9: After the last readback byte (also for a count of 0), chip-select drops and exactly one more clock pulse follows, then success is flagged.
- R10: A start while an operation runs is ignored. Success and failure are mutually exclusive and hold until the next start. Abort is a single-cycle pulse.
- R11: The data bus is driven only in load mode, and drive changes only while chip-select is low in both the current and the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe, taken when idle |
| rd_mode | input | 1 | 1 = readback, 0 = load |
| byte_cnt | input | CNT_W | Number of bytes to load or read |
| wr_data | input | 8 | Load byte stream data |
| wr_valid | input | 1 | Load byte available |
| wr_ready | output | 1 | Load byte taken this cycle |
| rd_data | output | 8 | Captured readback byte |
| rd_valid | output | 1 | Readback byte offered |
| rd_ready | input | 1 | Consumer takes readback byte |
| ok_o | output | 1 | Operation succeeded (held) |
| fail_o | output | 1 | Operation failed (held) |
| abort_o | output | 1 | One-cycle abort pulse |
| prog_o | output | 1 | Program request to target |
| cclk_o | output | 1 | Configuration clock |
| cs_o | output | 1 | Chip-select, active high |
| wr_o | output | 1 | Write enable, active high |
| d_out | output | 8 | Data bus drive value |
| d_oe | output | 1 | Data bus drive enable |
| d_in | input | 8 | Data bus sampled value |
| init_i | input | 1 | Target init indication, active high |
| busy_i | input | 1 | Target busy |
| done_i | input | 1 | Target done |

## Verification
The bench models the target as a set of reactions to the configuration clock. Loads are swept over every length from 1 to 6, with the release hold alternating between immediate and extended, which separates the both-high release rule from a wait on init alone. Short and overlong busy holds tell apart proper throttling and the busy timeout. A missing init, an init raised mid-stream, an early done and a done that never comes each isolate one exit path, and the byte and filler counts show where the sequence stopped. Readback is swept from 0 to 4 bytes with and without consumer stalls, and a stray start during a load checks that the running operation is left alone.

// File: rtl/cfg_par_pkg.sv
// Shared state encoding and constants for the byte-wide configuration loader.
package cfg_par_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PROG,
        S_CLR,
        S_PAUSE,
        S_CHK,
        S_WLOW,
        S_WHIGH,
        S_WBUSY,
        S_TAIL,
        S_FCHK,
        S_FLOW,
        S_FHIGH,
        S_RSEL,
        S_RCHK,
        S_RLOW,
        S_RHIGH,
        S_RWAIT,
        S_REND,
        S_XLOW,
        S_XHIGH,
        S_OK,
        S_ABORT
    } cfg_state_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/cfg_timer.sv
// Down-counting wait limit. Loading sets the count; it then decrements to
// zero and reports expiry. Assumes the owner loads it before each wait.
module cfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cfg_hit_counter.sv
// Counts completion observations and saturates. full is high once NEED
// observations have been recorded. Assumes clr precedes each use.
module cfg_hit_counter #(
    parameter int NEED = 8,
    parameter int W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full
);

    logic [W-1:0] cnt;

    // Clear, or increment while below the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && !full) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt >= W'(NEED));

endmodule

// File: rtl/cfg_par_master.sv
// Byte-wide configuration port master. In load mode it runs the program /
// init handshake, streams bytes with busy throttling, then clocks filler
// bytes until completion. In readback mode it clocks bytes out of the
// target into a valid/ready consumer. All waits are bounded by cycle-count
// limits. Assumes target status inputs are already synchronous to clk.
module cfg_par_master
    import cfg_par_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int INIT_TO   = 25_000_000,
    parameter int BUSY_TO   = 250_000,
    parameter int CFG_TO    = 10_000_000,
    parameter int PAUSE_CYC = 500_000,
    parameter int DONE_HITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_mode,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             ok_o,
    output logic             fail_o,
    output logic             abort_o,
    output logic             prog_o,
    output logic             cclk_o,
    output logic             cs_o,
    output logic             wr_o,
    output logic [7:0]       d_out,
    output logic             d_oe,
    input  logic [7:0]       d_in,
    input  logic             init_i,
    input  logic             busy_i,
    input  logic             done_i
);

    localparam int MAX_A  = (INIT_TO > BUSY_TO) ? INIT_TO : BUSY_TO;
    localparam int MAX_B  = (CFG_TO > PAUSE_CYC) ? CFG_TO : PAUSE_CYC;
    localparam int MAX_TO = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W  = $clog2(MAX_TO + 1);
    localparam int HIT_W  = $clog2(DONE_HITS + 1);

    cfg_state_e         state, nxt;
    logic [CNT_W-1:0]   remain;
    logic [7:0]         dq, rdq;
    logic               rdv, ok_q, fail_q, oe_q;
    logic               tmr_load, tmr_exp;
    logic [TMR_W-1:0]   tmr_val;
    logic               hit_clr, hit_inc, hit_full;
    logic               take_wr, rem_zero, done_seen;

    assign rem_zero  = (remain == '0);
    assign done_seen = done_i && !init_i;
    assign take_wr   = (state == S_CHK) && !done_i && !rem_zero && !init_i && wr_valid;

    cfg_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    cfg_hit_counter #(.NEED(DONE_HITS), .W(HIT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hit_clr),
        .inc   (hit_inc),
        .full  (hit_full)
    );

    // Next-state selection plus timer and counter controls.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(INIT_TO);
        hit_clr  = 1'b0;
        hit_inc  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt      = rd_mode ? S_RSEL : S_PROG;
                    tmr_load = 1'b1;
                end
            end
            S_PROG: begin
                if (init_i) begin
                    nxt      = S_CLR;
                    tmr_load = 1'b1;
                end else if (tmr_exp) begin
                    nxt = S_ABORT;
                end
            end
            S_CLR: begin
                if (!(init_i && busy_i)) begin
                    nxt      = S_PAUSE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PAUSE_CYC);
                end else if (tmr_exp) begin
                    nxt = S_ABORT;
                end
            end
            S_PAUSE: begin
                if (tmr_exp) nxt = S_CHK;
            end
            S_CHK: begin
                if (done_i || rem_zero) nxt = S_TAIL;
                else if (init_i)        nxt = S_ABORT;
                else if (wr_valid)      nxt = S_WLOW;
            end
            S_WLOW:  nxt = S_WHIGH;
            S_WHIGH: begin
                nxt      = S_WBUSY;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(BUSY_TO);
            end
            S_WBUSY: begin
                if (!busy_i)      nxt = S_CHK;
                else if (tmr_exp) nxt = S_ABORT;
            end
            S_TAIL: begin
                nxt      = S_FCHK;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CFG_TO);
                hit_clr  = 1'b1;
            end
            S_FCHK: begin
                if (done_seen && hit_full) begin
                    nxt = S_OK;
                end else if (tmr_exp) begin
                    nxt = S_ABORT;
                end else begin
                    nxt     = S_FLOW;
                    hit_inc = done_seen;
                end
            end
            S_FLOW:  nxt = S_FHIGH;
            S_FHIGH: nxt = S_FCHK;
            S_RSEL:  nxt = S_RCHK;
            S_RCHK:  nxt = rem_zero ? S_REND : S_RLOW;
            S_RLOW:  nxt = S_RHIGH;
            S_RHIGH: nxt = S_RWAIT;
            S_RWAIT: begin
                if (rd_ready) nxt = S_RCHK;
            end
            S_REND:  nxt = S_XLOW;
            S_XLOW:  nxt = S_XHIGH;
            S_XHIGH: nxt = S_OK;
            S_OK:    nxt = S_IDLE;
            S_ABORT: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Remaining byte count: loaded at launch, decremented per byte moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (state == S_IDLE && start) begin
            remain <= byte_cnt;
        end else if (take_wr || state == S_RHIGH) begin
            remain <= remain - 1'b1;
        end
    end

    // Outgoing bus value: stream byte on acceptance, filler at stream end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq <= '0;
        end else if (take_wr) begin
            dq <= wr_data;
        end else if (state == S_TAIL) begin
            dq <= FILL_BYTE;
        end
    end

    // Readback capture register and its offer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdq <= '0;
            rdv <= 1'b0;
        end else if (state == S_RHIGH) begin
            rdq <= d_in;
            rdv <= 1'b1;
        end else if (state == S_RWAIT && rd_ready) begin
            rdv <= 1'b0;
        end
    end

    // Held outcome flags, cleared by a new launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else if (state == S_IDLE && start) begin
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
        end else if (state == S_OK) begin
            ok_q <= 1'b1;
        end else if (state == S_ABORT) begin
            fail_q <= 1'b1;
        end
    end

    // Bus drive enable: on at a load launch, off at the end; chip-select low both times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (state == S_IDLE && start) begin
            oe_q <= !rd_mode;
        end else if (state == S_OK || state == S_ABORT) begin
            oe_q <= 1'b0;
        end
    end

    // Pin levels decoded from state.
    always_comb begin
        prog_o = (state == S_PROG);
        cclk_o = !(state inside {S_WLOW, S_FLOW, S_RLOW, S_XLOW});
        wr_o   = state inside {S_PAUSE, S_CHK, S_WLOW, S_WHIGH, S_WBUSY};
        cs_o   = wr_o || (state inside {S_RSEL, S_RCHK, S_RLOW, S_RHIGH, S_RWAIT});
    end

    assign wr_ready = take_wr;
    assign rd_data  = rdq;
    assign rd_valid = rdv;
    assign ok_o     = ok_q;
    assign fail_o   = fail_q;
    assign abort_o  = (state == S_ABORT);
    assign d_out    = dq;
    assign d_oe     = oe_q;

endmodule

// File: rtl/cfg_par_master_chk.sv
// Protocol checker for the configuration loader, attached by bind.
// Assumes only that rst_n is low from time zero until the first edges.
module cfg_par_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_o,
    input logic       cclk_o,
    input logic       cs_o,
    input logic       wr_o,
    input logic       d_oe,
    input logic       init_i,
    input logic       busy_i,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       ok_o,
    input logic       fail_o,
    input logic       abort_o
);

    a_r1_prog_cs_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_o && cs_o));

    a_r2_open_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_o) && wr_o) |-> !($past(init_i) && $past(busy_i)));

    a_r4_no_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cclk_o) && wr_o) |-> !$past(busy_i));

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && cclk_o));

    a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && fail_o));

    a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!abort_o && fail_o));

    a_r11_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o && !wr_o) |-> !d_oe);

    a_r11_switch_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (d_oe != $past(d_oe)) |-> (!cs_o && !$past(cs_o)));

endmodule

bind cfg_par_master cfg_par_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_o   (prog_o),
    .cclk_o   (cclk_o),
    .cs_o     (cs_o),
    .wr_o     (wr_o),
    .d_oe     (d_oe),
    .init_i   (init_i),
    .busy_i   (busy_i),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .ok_o     (ok_o),
    .fail_o   (fail_o),
    .abort_o  (abort_o)
);

// File: tb/cfg_par_master_tb.sv
// Bench: a behavioural target reacting to the configuration clock, a byte
// source and a consumer; all expectations are counted from the requirements.
module cfg_par_master_tb;

    localparam int CW    = 8;
    localparam int PAUSE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_mode = 1'b0;
    logic [CW-1:0] byte_cnt = '0;
    logic [7:0]    wr_data;
    logic          wr_valid, wr_ready;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          rd_ready = 1'b1;
    logic          ok_o, fail_o, abort_o, prog_o, cclk_o, cs_o, wr_o, d_oe;
    logic [7:0]    d_out;
    logic [7:0]    d_in_m = 8'h00;
    logic          init_m = 1'b0, busy_m = 1'b0, done_m = 1'b0;

    always #10 clk = ~clk;

    cfg_par_master #(
        .CNT_W(CW), .INIT_TO(20), .BUSY_TO(12), .CFG_TO(60),
        .PAUSE_CYC(PAUSE), .DONE_HITS(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
        .byte_cnt(byte_cnt), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .ok_o(ok_o), .fail_o(fail_o), .abort_o(abort_o),
        .prog_o(prog_o), .cclk_o(cclk_o), .cs_o(cs_o), .wr_o(wr_o),
        .d_out(d_out), .d_oe(d_oe), .d_in(d_in_m), .init_i(init_m),
        .busy_i(busy_m), .done_i(done_m)
    );

    // Byte source
    logic [7:0] wsrc [0:15];
    int         widx = 0;
    int         wlen = 0;
    logic       launch = 1'b0;
    assign wr_valid = (widx < wlen);
    assign wr_data  = wsrc[widx[3:0]];
    always @(posedge clk) begin
        if (launch) widx <= 0;
        else if (wr_valid && wr_ready) widx <= widx + 1;
    end

    // Scenario knobs and observations
    int   sc_done_after, sc_init_err, sc_bhold, sc_rhold;
    bit   sc_noinit, bp_mode, mreset;
    int   nw, nfill, nrd, nxtra, nclk_rd, nfall_busy, ncs_bad, ncs_rise, naborts, nbad_oe;
    int   cyc, cs_cyc, gap, bcnt, rcnt;
    logic cclk_q = 1'b1, cs_q = 1'b0, prog_q = 1'b0;
    logic [7:0] wbytes [0:15];
    logic [7:0] rbytes [0:15];
    int   checks = 0, errors = 0, gcyc = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'(8'h5A ^ (i * 37));
    endfunction

    // Target model, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (mreset) begin
            nw = 0; nfill = 0; nxtra = 0; nclk_rd = 0; nfall_busy = 0;
            ncs_bad = 0; ncs_rise = 0; naborts = 0; nbad_oe = 0;
            gap = -1; cs_cyc = 0; bcnt = 0; rcnt = 0;
            init_m = 1'b0; busy_m = 1'b0; done_m = 1'b0;
        end else if (rst_n) begin
            if (!cclk_o && cclk_q && busy_m && cs_o && wr_o) nfall_busy++;
            if (cs_o && !cs_q) begin
                ncs_rise++;
                cs_cyc = cyc;
                if (init_m && busy_m) ncs_bad++;
            end
            if (!cclk_o && cclk_q && cs_o && wr_o && nw == 0 && gap < 0) gap = cyc - cs_cyc;
            if (abort_o) naborts++;
            if (prog_o) begin
                if (!sc_noinit) init_m = 1'b1;
                busy_m = 1'b0; done_m = 1'b0;
            end else if (prog_q) begin
                if (sc_rhold > 0) begin busy_m = 1'b1; rcnt = sc_rhold; end
                else init_m = 1'b0;
            end else if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) begin init_m = 1'b0; busy_m = 1'b0; end
            end
            if (cclk_o && !cclk_q) begin
                if (cs_o && wr_o) begin
                    wbytes[nw[3:0]] = d_out;
                    nw++;
                    if (nw == sc_done_after) done_m = 1'b1;
                    if (nw == sc_init_err) init_m = 1'b1;
                    if (sc_bhold > 0) begin busy_m = 1'b1; bcnt = sc_bhold; end
                end else if (!cs_o && d_oe) begin
                    if (d_out == 8'hFF) nfill++;
                end else if (cs_o && !wr_o) begin
                    if (d_oe) nbad_oe++;
                    d_in_m = pat(nclk_rd);
                    nclk_rd++;
                end else begin
                    nxtra++;
                end
            end else if (bcnt > 0) begin
                bcnt--;
                if (bcnt == 0) busy_m = 1'b0;
            end
        end
        cclk_q = cclk_o; cs_q = cs_o; prog_q = prog_o;
    end

    // Consumer with optional stalls.
    int ccyc = 0;
    always @(negedge clk) begin
        ccyc++;
        rd_ready = bp_mode ? ((ccyc % 3) == 2) : 1'b1;
        if (mreset) nrd = 0;
        else if (rd_valid && rd_ready) begin
            rbytes[nrd[3:0]] = rd_data;
            nrd++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=%0d", gcyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input int n, input int dafter, input int ierr,
                         input int bh, input int rh, input bit noinit);
        sc_done_after = dafter; sc_init_err = ierr; sc_bhold = bh;
        sc_rhold = rh; sc_noinit = noinit; wlen = n;
        for (int i = 0; i < 16; i++) wsrc[i] = 8'(8'hC3 + i * 29);
        @(negedge clk) mreset = 1'b1;
        @(negedge clk);
        @(negedge clk) mreset = 1'b0;
    endtask

    task automatic go(input bit rm, input int n);
        @(negedge clk);
        rd_mode = rm; byte_cnt = CW'(n); start = 1'b1; launch = 1'b1;
        @(negedge clk);
        start = 1'b0; launch = 1'b0;
    endtask

    task automatic finish_op(input string tag);
        int t;
        t = 0;
        while (!(ok_o || fail_o) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 4000, {tag, " completes"}, t, 4000);
        repeat (3) @(negedge clk);
    endtask

    function automatic int wmis(input int n);
        int m;
        m = 0;
        for (int i = 0; i < n; i++) if (wbytes[i] !== wsrc[i]) m++;
        return m;
    endfunction

    function automatic int rmis(input int n);
        int m;
        m = 0;
        for (int i = 0; i < n; i++) if (rbytes[i] !== pat(i)) m++;
        return m;
    endfunction

    initial begin
        bp_mode = 1'b0; mreset = 1'b0;
        sc_done_after = -1; sc_init_err = -1; sc_bhold = 0; sc_rhold = 0; sc_noinit = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset levels
        chk(!prog_o && !cs_o && !wr_o && cclk_o && !d_oe, "R1 reset pins",
            {prog_o, cs_o, wr_o, cclk_o, d_oe}, 5'b00010);
        chk(!ok_o && !fail_o && !abort_o, "R1 reset status", {ok_o, fail_o, abort_o}, 0);
        @(negedge clk) rst_n = 1'b1;

        // R2 R3 R4 R6: load sweep, release hold alternating
        for (int n = 1; n <= 6; n++) begin
            setup(n, n, -1, 0, (n % 2 == 0) ? 5 : 0, 1'b0);
            go(1'b0, n);
            finish_op("R4 load");
            chk(ok_o && !fail_o, "R6 load success", ok_o, 1);
            chk(nw == n, "R4 byte count", nw, n);
            chk(wmis(n) == 0, "R4 byte order/value", wmis(n), 0);
            chk(nfill == 8, "R6 filler pulses", nfill, 8);
            chk(ncs_bad == 0, "R2 opened during init&busy", ncs_bad, 0);
            chk(gap >= PAUSE, "R3 settle pause", gap, PAUSE);
            chk(!cs_o && !wr_o && !d_oe, "R11 idle after load", {cs_o, wr_o, d_oe}, 0);
        end

        // R4 busy throttling within limit
        setup(4, 4, -1, 6, 0, 1'b0);
        go(1'b0, 4);
        finish_op("R4 busy");
        chk(ok_o, "R4 throttled load ok", ok_o, 1);
        chk(nw == 4 && wmis(4) == 0, "R4 throttled bytes", nw, 4);
        chk(nfall_busy == 0, "R4 no strobe in busy", nfall_busy, 0);

        // R4 busy timeout
        setup(4, 4, -1, 30, 0, 1'b0);
        go(1'b0, 4);
        finish_op("R4 busy timeout");
        chk(fail_o && !ok_o, "R4 busy timeout fails", fail_o, 1);
        chk(nw == 1, "R4 stops after stuck byte", nw, 1);
        chk(naborts == 1, "R10 single abort", naborts, 1);

        // R2 init never seen
        setup(3, 3, -1, 0, 0, 1'b1);
        go(1'b0, 3);
        finish_op("R2 init timeout");
        chk(fail_o, "R2 init timeout fails", fail_o, 1);
        chk(ncs_rise == 0, "R2 port never opened", ncs_rise, 0);
        chk(naborts == 1, "R2 abort pulse", naborts, 1);

        // R5 init mid-stream
        setup(5, -1, 2, 0, 0, 1'b0);
        go(1'b0, 5);
        finish_op("R5 init error");
        chk(fail_o, "R5 init error fails", fail_o, 1);
        chk(nw == 2, "R5 bytes before error", nw, 2);

        // R5 done early
        setup(5, 2, -1, 0, 0, 1'b0);
        go(1'b0, 5);
        finish_op("R5 early done");
        chk(ok_o, "R5 early done ok", ok_o, 1);
        chk(nw == 2, "R5 stream cut short", nw, 2);
        chk(nfill == 8, "R6 fillers after early done", nfill, 8);

        // R6 completion never reported
        setup(2, -1, -1, 0, 0, 1'b0);
        go(1'b0, 2);
        finish_op("R6 cfg timeout");
        chk(fail_o, "R6 cfg timeout fails", fail_o, 1);
        chk(nfill > 8, "R6 fillers until limit", nfill, 9);
        chk(naborts == 1, "R6 abort pulse", naborts, 1);

        // R7 R8 R9 readback sweep, with and without stalls
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n <= 4; n++) begin
                bp_mode = (b == 1);
                setup(0, -1, -1, 0, 0, 1'b0);
                go(1'b1, n);
                finish_op("R7 readback");
                chk(ok_o, "R9 readback success", ok_o, 1);
                chk(nrd == n, b ? "R8 count under stall" : "R7 byte count", nrd, n);
                chk(rmis(n) == 0, b ? "R8 data under stall" : "R7 byte values", rmis(n), 0);
                chk(nxtra == 1, "R9 one trailing pulse", nxtra, 1);
                chk(nbad_oe == 0, "R11 bus undriven in read", nbad_oe, 0);
            end
        end
        bp_mode = 1'b0;

        // R10 stray start ignored, status held
        setup(3, 3, -1, 0, 0, 1'b0);
        go(1'b0, 3);
        repeat (3) @(negedge clk);
        rd_mode = 1'b1; byte_cnt = CW'(7); start = 1'b1;
        @(negedge clk) start = 1'b0;
        finish_op("R10 stray start");
        chk(ok_o && nw == 3, "R10 stray start ignored", nw, 3);
        chk(nrd == 0 && nclk_rd == 0, "R10 no readback started", nclk_rd, 0);
        repeat (10) @(negedge clk);
        chk(ok_o && !fail_o, "R10 status held", ok_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule